// File: doc/BRIEF.md
# Ring Neighbour Key Suppression Arbiter

This block decides which of a ring of touch-key channels may drive its output high. Each channel gives the block a detect flag, meaning its signal is above threshold, and an unsigned strength value. The keys form a closed ring. Key 0 and key NUM_KEYS-1 count as neighbours, like every consecutive pair. An idle key that starts detecting is checked against its two neighbours before its output turns on. The key is held back when either neighbour's output is already active. It is also held back when a detecting neighbour reports a larger strength. Once a key's output is on, it keeps that output for as long as it keeps detecting, whatever its neighbours do.

For every key that is detecting but not granted, the block raises a drift-hold flag. The baseline tracker that sits outside this block uses that flag to stop adapting on the key. When the build parameter `SUPPRESS_EN` is 0, the neighbour check is removed: each output follows its own detect flag, and the drift-hold flags stay low. All inputs are sampled on every clock. Outputs and flags are registered, so they change one edge after the inputs that cause them. The channels are plain level signals, sampled every cycle. There is no valid/ready handshake and no back-pressure, because the arbiter never stalls its sources.

Top module: `key_ring_arbiter`

## Requirements
- R1: When the synchronous active-high `rst` is high at a clock edge, all `key_out` and `drift_hold` bits are 0 after that edge.
- R2: A key whose output is on keeps it on at the next edge while its detect flag is 1, and turns it off at the next edge once its detect flag is 0, whatever its neighbours do.
- R3: An idle key with a detect flag of 1 stays off if the output of either ring neighbour is currently on. Bit i of each vector is key i; key i's neighbours are keys (i-1) mod NUM_KEYS and (i+1) mod NUM_KEYS.
- R4: An idle key with a detect flag of 1 stays off if a ring neighbour that is also detecting has a strictly larger strength. Key i's strength is `key_strength[i*STR_W +: STR_W]`.
- R5: When an idle key and a detecting neighbour have equal strength, the lower-indexed key of the pair wins. On the wrap pair, key 0 beats key NUM_KEYS-1.
- R6: With suppression enabled, two ring-neighbour outputs are never on at the same time.
- R7: An idle detecting key with no blocking neighbour turns its output on at the next edge.
- R8: With suppression enabled, `drift_hold[i]` after an edge is 1 exactly when key i was detecting at that edge and its output after the edge is off.
- R9: With `SUPPRESS_EN` = 0, each `key_out` bit equals its detect flag one edge later, and `drift_hold` stays 0.
- R10: When a winning key stops detecting, its output drops at the next edge. A still-detecting neighbour that it was blocking is then re-evaluated and turns on one edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| key_det | input | NUM_KEYS | Per-key above-threshold flag |
| key_strength | input | NUM_KEYS*STR_W | Packed unsigned strengths, key i at bits i*STR_W upward |
| key_out | output | NUM_KEYS | Registered per-key output |
| drift_hold | output | NUM_KEYS | Registered per-key drift-freeze flag |

## Verification
The bench builds two copies with NUM_KEYS = 6 and STR_W = 8. One has `SUPPRESS_EN` = 1 and the other has `SUPPRESS_EN` = 0, and both see the same stimulus. The suppressing copy covers wrap-around neighbours, the priority of an active output, strict strength comparison and ties. During random traffic, strengths are drawn from a narrow range so that equal values occur often. The independent copy shows that removing the parameter turns each channel into a one-cycle delayed follower with no drift hold.

// File: rtl/key_ring_pkg.sv
package key_ring_pkg;

  function automatic int ring_prev(input int idx, input int n);
    return (idx == 0) ? n - 1 : idx - 1;
  endfunction

  function automatic int ring_next(input int idx, input int n);
    return (idx == n - 1) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/key_ring_gather.sv
module key_ring_gather #(
  parameter int NUM_KEYS = 6,
  parameter int STR_W    = 8
) (
  input  logic [NUM_KEYS-1:0]       det,
  input  logic [NUM_KEYS-1:0]       act,
  input  logic [NUM_KEYS*STR_W-1:0] str,
  output logic [NUM_KEYS-1:0]       prv_det,
  output logic [NUM_KEYS-1:0]       prv_act,
  output logic [NUM_KEYS*STR_W-1:0] prv_str,
  output logic [NUM_KEYS-1:0]       nxt_det,
  output logic [NUM_KEYS-1:0]       nxt_act,
  output logic [NUM_KEYS*STR_W-1:0] nxt_str
);
  import key_ring_pkg::*;

  // Route each key's two ring neighbours onto aligned lanes
  for (genvar g = 0; g < NUM_KEYS; g++) begin : g_lane
    localparam int P = ring_prev(g, NUM_KEYS);
    localparam int N = ring_next(g, NUM_KEYS);
    assign prv_det[g] = det[P];
    assign prv_act[g] = act[P];
    assign prv_str[g*STR_W +: STR_W] = str[P*STR_W +: STR_W];
    assign nxt_det[g] = det[N];
    assign nxt_act[g] = act[N];
    assign nxt_str[g*STR_W +: STR_W] = str[N*STR_W +: STR_W];
  end

endmodule

// File: rtl/key_ring_judge.sv
module key_ring_judge #(
  parameter int STR_W       = 8,
  parameter bit PRV_LOWER   = 1'b1,
  parameter bit NXT_LOWER   = 1'b0,
  parameter bit SUPPRESS_EN = 1'b1
) (
  input  logic             det,
  input  logic             act,
  input  logic [STR_W-1:0] str,
  input  logic             prv_det,
  input  logic             prv_act,
  input  logic [STR_W-1:0] prv_str,
  input  logic             nxt_det,
  input  logic             nxt_act,
  input  logic [STR_W-1:0] nxt_str,
  output logic             act_d,
  output logic             hold_d
);

  logic prv_beats, nxt_beats, blocked;

  // A detecting neighbour wins on larger strength, or on a tie if lower-indexed
  always_comb begin
    prv_beats = prv_det && ((prv_str > str) || (PRV_LOWER && (prv_str == str)));
    nxt_beats = nxt_det && ((nxt_str > str) || (NXT_LOWER && (nxt_str == str)));
    blocked   = prv_act || nxt_act || prv_beats || nxt_beats;
  end

  if (SUPPRESS_EN) begin : g_arb
    always_comb begin
      if (act) act_d = det;              // granted key is never re-arbitrated
      else     act_d = det && !blocked;
      hold_d = det && !act_d;
    end
  end else begin : g_free
    always_comb begin
      act_d  = det;
      hold_d = 1'b0;
    end
  end

endmodule

// File: rtl/key_ring_arbiter.sv
module key_ring_arbiter #(
  parameter int NUM_KEYS    = 6,
  parameter int STR_W       = 8,
  parameter bit SUPPRESS_EN = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_KEYS-1:0]       key_det,
  input  logic [NUM_KEYS*STR_W-1:0] key_strength,
  output logic [NUM_KEYS-1:0]       key_out,
  output logic [NUM_KEYS-1:0]       drift_hold
);
  import key_ring_pkg::*;

  logic [NUM_KEYS-1:0]       prv_det, prv_act, nxt_det, nxt_act;
  logic [NUM_KEYS*STR_W-1:0] prv_str, nxt_str;
  logic [NUM_KEYS-1:0]       act_d, hold_d;

  key_ring_gather #(.NUM_KEYS(NUM_KEYS), .STR_W(STR_W)) u_gather (
    .det(key_det), .act(key_out), .str(key_strength),
    .prv_det(prv_det), .prv_act(prv_act), .prv_str(prv_str),
    .nxt_det(nxt_det), .nxt_act(nxt_act), .nxt_str(nxt_str)
  );

  for (genvar g = 0; g < NUM_KEYS; g++) begin : g_key
    localparam int P = ring_prev(g, NUM_KEYS);
    localparam int N = ring_next(g, NUM_KEYS);
    key_ring_judge #(
      .STR_W(STR_W), .PRV_LOWER(P < g), .NXT_LOWER(N < g),
      .SUPPRESS_EN(SUPPRESS_EN)
    ) u_judge (
      .det(key_det[g]), .act(key_out[g]), .str(key_strength[g*STR_W +: STR_W]),
      .prv_det(prv_det[g]), .prv_act(prv_act[g]), .prv_str(prv_str[g*STR_W +: STR_W]),
      .nxt_det(nxt_det[g]), .nxt_act(nxt_act[g]), .nxt_str(nxt_str[g*STR_W +: STR_W]),
      .act_d(act_d[g]), .hold_d(hold_d[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      key_out    <= '0;
      drift_hold <= '0;
    end else begin
      key_out    <= act_d;
      drift_hold <= hold_d;
    end
  end

  // Checks next to the state they guard
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (key_out == '0 && drift_hold == '0));

  for (genvar g = 0; g < NUM_KEYS; g++) begin : g_chk
    localparam int N = ring_next(g, NUM_KEYS);
    a_r2_keeps_on: assert property (@(posedge clk) disable iff (rst)
      (key_out[g] && key_det[g]) |=> key_out[g]);
    a_r2_drops_off: assert property (@(posedge clk) disable iff (rst)
      !key_det[g] |=> !key_out[g]);
    if (SUPPRESS_EN) begin : g_sup
      a_r6_no_adjacent: assert property (@(posedge clk) disable iff (rst)
        !(key_out[g] && key_out[N]));
      a_r3_blocked_by_active: assert property (@(posedge clk) disable iff (rst)
        (key_out[N] && !key_out[g]) |=> !key_out[g]);
      a_r8_hold_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(drift_hold[g] && key_out[g]));
    end else begin : g_free_chk
      a_r9_no_hold: assert property (@(posedge clk) disable iff (rst) !drift_hold[g]);
    end
  end

endmodule

// File: tb/key_ring_arbiter_bench.sv
module key_ring_arbiter_bench;
  localparam int NK = 6;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NK-1:0]    det = '0;
  logic [NK*SW-1:0] str = '0;
  logic [NK-1:0] out_a, hold_a, out_b, hold_b;

  logic [NK-1:0] m_out_a = '0, m_hold_a = '0, m_out_b = '0, m_hold_b = '0;
  int n_cmp = 0;
  int n_bad = 0;
  string tag = "R1";
  bit done = 0;

  always #4 clk = ~clk;

  key_ring_arbiter #(.NUM_KEYS(NK), .STR_W(SW), .SUPPRESS_EN(1'b1)) u_key_ring_arbiter (
    .clk(clk), .rst(rst), .key_det(det), .key_strength(str),
    .key_out(out_a), .drift_hold(hold_a));

  key_ring_arbiter #(.NUM_KEYS(NK), .STR_W(SW), .SUPPRESS_EN(1'b0)) u_key_ring_arbiter_free (
    .clk(clk), .rst(rst), .key_det(det), .key_strength(str),
    .key_out(out_b), .drift_hold(hold_b));

  function automatic int sval(input int k);
    return int'(str[k*SW +: SW]);
  endfunction

  // Behavioural reference: evaluated once per rising edge from the stimulus
  task automatic model_edge();
    logic [NK-1:0] na, nh;
    if (rst) begin
      m_out_a = '0; m_hold_a = '0; m_out_b = '0; m_hold_b = '0;
      return;
    end
    for (int i = 0; i < NK; i++) begin
      bit stop = 0;
      int nb[2];
      nb[0] = (i + NK - 1) % NK;
      nb[1] = (i + 1) % NK;
      foreach (nb[k]) begin
        int j = nb[k];
        if (m_out_a[j]) stop = 1;
        if (det[j] && (sval(j) > sval(i) || (sval(j) == sval(i) && j < i))) stop = 1;
      end
      if (m_out_a[i]) na[i] = det[i];
      else            na[i] = det[i] && !stop;
      nh[i] = det[i] && !na[i];
    end
    m_out_a = na; m_hold_a = nh;
    m_out_b = det; m_hold_b = '0;
  endtask

  task automatic compare();
    n_cmp++;
    if (out_a !== m_out_a || hold_a !== m_hold_a) begin
      n_bad++;
      $display("FAIL %s suppressing: out=%b hold=%b expected out=%b hold=%b",
               tag, out_a, hold_a, m_out_a, m_hold_a);
    end
    n_cmp++;
    if (out_b !== m_out_b || hold_b !== m_hold_b) begin
      n_bad++;
      $display("FAIL R9 independent: out=%b hold=%b expected out=%b hold=%b",
               out_b, hold_b, m_out_b, m_hold_b);
    end
    for (int i = 0; i < NK; i++) begin
      n_cmp++;
      if (out_a[i] && out_a[(i + 1) % NK]) begin
        n_bad++;
        $display("FAIL R6 adjacent pair %0d/%0d: out=%b expected no neighbours both on",
                 i, (i + 1) % NK, out_a);
      end
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic set_str(input int k, input int v);
    str[k*SW +: SW] = SW'(v);
  endtask

  task automatic idle();
    tag = "R2"; det = '0; step(); step();
  endtask

  initial begin
    // R1: reset with busy inputs
    tag = "R1"; rst = 1; det = 6'b111111; step(); step();
    rst = 0; det = '0; str = '0; step();

    // R7: lone key turns on
    tag = "R7"; set_str(2, 40); det = 6'b000100; step();
    // R3 and R8: stronger neighbour loses to an active output
    tag = "R3"; set_str(3, 90); det = 6'b001100; step(); step();
    // R10: winner releases, neighbour follows one edge later
    tag = "R10"; det = 6'b001000; step(); step(); step();
    // R2: release
    tag = "R2"; det = '0; step();
    idle();

    // R4: strict strength, wrap neighbour
    tag = "R4"; set_str(0, 10); set_str(1, 20); det = 6'b000011; step(); step();
    idle();
    tag = "R4"; set_str(5, 70); set_str(0, 30); det = 6'b100001; step();
    idle();
    // R5: ties, plain pair and wrap pair
    tag = "R5"; set_str(4, 55); set_str(5, 55); det = 6'b110000; step();
    idle();
    tag = "R5"; set_str(5, 12); set_str(0, 12); det = 6'b100001; step();
    idle();
    // R3: wrap, active key 0 blocks key 5
    tag = "R3"; set_str(0, 1); det = 6'b000001; step();
    set_str(5, 200); det = 6'b100001; step(); step();
    idle();

    // Random traffic with narrow strengths for ties
    for (int c = 0; c < 4000; c++) begin
      rst = ($urandom_range(0, 199) == 0);
      tag = rst ? "R1" : "R6";
      if ($urandom_range(0, 2) == 0) det = NK'($urandom);
      for (int k = 0; k < NK; k++)
        if ($urandom_range(0, 3) == 0) set_str(k, $urandom_range(0, 3));
      step();
    end
    rst = 0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected finish before timeout");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule